// File: doc/BRIEF.md
# Mailbox command requester

This block sends commands, one at a time, to a firmware-style responder. The responder is reached through three mailbox registers on a simple register bus: a message register, a parameter register and a response register. A client hands over a 16-bit message index and a 32-bit parameter on a valid/ready handshake. The engine then polls the response register to confirm that the responder has finished the previous command. It writes the mailbox in a fixed order and polls again for the new response. It returns a 3-bit result class together with the 32-bit argument that the responder leaves in the parameter register.

Polling runs at one read per microsecond. The microsecond comes from a clock prescaler (`CLK_PER_US`). Each poll phase allows at most `20 * BASE_COUNT` reads. When `HALT_ON_ERR` is set, a sticky halt output is raised by the first command that does not end with OK.

The register bus is a single-cycle master. A transfer happens in every cycle with `reg_req_o` high. Writes take effect at that clock edge. For reads, `reg_rdata_i` must show the addressed register in the same cycle.

Top module: `mbox_cmd_requester`

## Requirements
- R1: `req_ready_o` is high only when the engine is idle. It falls in the cycle after a request is accepted and stays low through the cycle in which `done_o` pulses. `done_o` is high for exactly one cycle per command, and `result_o`/`arg_o` are valid in that cycle.
- R2: Pre-send check, timeout case. The engine reads the response register (`RESP_ADDR`) once per microsecond tick. If all `20*BASE_COUNT` reads return zero, the command ends with TIMEOUT (code 1), no register is written, and `arg_o` is 0.
- R3: Pre-send check, undefined code. If the first nonzero pre-send response is undefined (any 32-bit value except 0x01, 0xFC, 0xFD, 0xFE and 0xFF), the command ends at once with REMOTE_IO (code 6). No register is written and `arg_o` is 0.
- R4: Pre-send check, defined code. If the pre-send response is any defined nonzero code, including 0xFC and 0xFF, the command is sent.
- R5: Send order. Exactly three writes happen in consecutive cycles: 0 to `RESP_ADDR`, then the parameter to `PARAM_ADDR`, then the zero-extended message index to `MSG_ADDR`. Defaults: `MSG_ADDR`=0x00, `PARAM_ADDR`=0x04, `RESP_ADDR`=0x08.
- R6: Post-send timeout. After sending, polling restarts with a fresh budget of `20*BASE_COUNT` reads. If all of them return zero, the result is TIMEOUT, and the argument is still read.
- R7: Decode of the post-send response, with the result codes: 0x01 gives OK (0), 0xFF gives IO_FAIL (2), 0xFE gives UNSUPPORTED (3), 0xFD gives BAD_PREREQ (4), 0xFC gives BUSY (5, the client should retry after about 10 us), and any other nonzero value, 0xFB included, gives REMOTE_IO (6).
- R8: After the post-send poll, the engine always reads `PARAM_ADDR` once, whatever the result, and returns that value on `arg_o`.
- R9: With `HALT_ON_ERR`=1, `halt_o` stays low while every command returns OK. It rises with the `done_o` of the first non-OK result and never falls until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle, request can be accepted |
| req_idx_i | input | IDX_W | Message index |
| req_param_i | input | DATA_W | Message parameter |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 3 | Result class |
| arg_o | output | DATA_W | Argument read back from the parameter register |
| halt_o | output | 1 | Sticky halt on error |
| reg_req_o | output | 1 | Register transfer in this cycle |
| reg_we_o | output | 1 | Transfer is a write |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Write data |
| reg_rdata_i | input | DATA_W | Read data, same cycle |

## Verification
A wrong sequencing state shows at the register bus within one cycle. Symptoms include a write landing out of order, a write after an aborted pre-send check, or a missing argument read. A fault in the prescaler or the poll budget changes the number of response reads seen before a TIMEOUT, and that count is fixed at `20*BASE_COUNT` per phase. A decode fault shows as a wrong `result_o` in the single `done_o` cycle. A lost halt flag shows on the next command after an error.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [2:0] {
    RES_OK          = 3'd0,
    RES_TIMEOUT     = 3'd1,
    RES_IO_FAIL     = 3'd2,
    RES_UNSUPPORTED = 3'd3,
    RES_BAD_PREREQ  = 3'd4,
    RES_BUSY        = 3'd5,
    RES_REMOTE_IO   = 3'd6
  } result_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_POLL, ST_WR_RESP, ST_WR_PARAM,
    ST_WR_MSG, ST_POST_POLL, ST_RD_ARG, ST_DONE
  } state_e;

  localparam logic [7:0] CODE_OK      = 8'h01;
  localparam logic [7:0] CODE_FAIL    = 8'hFF;
  localparam logic [7:0] CODE_UNKNOWN = 8'hFE;
  localparam logic [7:0] CODE_PREREQ  = 8'hFD;
  localparam logic [7:0] CODE_BUSY    = 8'hFC;
endpackage

// File: rtl/mbox_tick_gen.sv
module mbox_tick_gen #(
  parameter int unsigned CLK_PER_US = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !clear_i && (cnt_q == LAST);

  if (CLK_PER_US > 1) begin : g_spacing
    assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int unsigned BASE_COUNT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic last_o
);
  localparam int unsigned LIMIT = 20 * BASE_COUNT;
  localparam int unsigned TW    = $clog2(LIMIT + 1);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      left_q <= '0;
    else if (load_i)                  left_q <= TW'(LIMIT);
    else if (dec_i && left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign last_o = (left_q == TW'(1));

  assert_budget_live_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> left_q != '0);
endmodule

// File: rtl/mbox_resp_decode.sv
module mbox_resp_decode
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] code_i,
  output result_e           class_o
);
  always_comb begin
    if (code_i == '0)                          class_o = RES_TIMEOUT;
    else if (code_i == DATA_W'(CODE_OK))       class_o = RES_OK;
    else if (code_i == DATA_W'(CODE_FAIL))     class_o = RES_IO_FAIL;
    else if (code_i == DATA_W'(CODE_UNKNOWN))  class_o = RES_UNSUPPORTED;
    else if (code_i == DATA_W'(CODE_PREREQ))   class_o = RES_BAD_PREREQ;
    else if (code_i == DATA_W'(CODE_BUSY))     class_o = RES_BUSY;
    else                                       class_o = RES_REMOTE_IO;
  end
endmodule

// File: rtl/mbox_cmd_requester.sv
module mbox_cmd_requester
  import mbox_pkg::*;
#(
  parameter int unsigned IDX_W       = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned CLK_PER_US  = 100,
  parameter int unsigned BASE_COUNT  = 10,
  parameter bit          HALT_ON_ERR = 1'b1,
  parameter logic [ADDR_W-1:0] MSG_ADDR   = 'h00,
  parameter logic [ADDR_W-1:0] PARAM_ADDR = 'h04,
  parameter logic [ADDR_W-1:0] RESP_ADDR  = 'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [DATA_W-1:0] req_param_i,
  output logic              done_o,
  output logic [2:0]        result_o,
  output logic [DATA_W-1:0] arg_o,
  output logic              halt_o,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int unsigned PAD_W = DATA_W - IDX_W;

  state_e            state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] param_q, arg_q;
  result_e           res_q, rd_class;
  logic              halt_q;

  logic accept, phase_start, tick, poll_rd, rd_zero, budget_last;

  assign accept      = (state_q == ST_IDLE) && req_valid_i;
  assign phase_start = accept || (state_q == ST_WR_MSG);
  assign poll_rd     = ((state_q == ST_PRE_POLL) || (state_q == ST_POST_POLL)) && tick;
  assign rd_zero     = (reg_rdata_i == '0);

  mbox_tick_gen #(.CLK_PER_US(CLK_PER_US)) i_tick (
    .clk_i, .rst_ni, .clear_i(phase_start), .tick_o(tick)
  );

  mbox_poll_timer #(.BASE_COUNT(BASE_COUNT)) i_timer (
    .clk_i, .rst_ni, .load_i(phase_start), .dec_i(poll_rd && rd_zero), .last_o(budget_last)
  );

  mbox_resp_decode #(.DATA_W(DATA_W)) i_dec (
    .code_i(reg_rdata_i), .class_o(rd_class)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      param_q <= '0;
      arg_q   <= '0;
      res_q   <= RES_OK;
      halt_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          idx_q   <= req_idx_i;
          param_q <= req_param_i;
          arg_q   <= '0;
          state_q <= ST_PRE_POLL;
        end
        ST_PRE_POLL: if (poll_rd) begin
          if (!rd_zero) begin
            if (rd_class == RES_REMOTE_IO) begin
              res_q   <= RES_REMOTE_IO;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_WR_RESP;
            end
          end else if (budget_last) begin
            res_q   <= RES_TIMEOUT;
            state_q <= ST_DONE;
          end
        end
        ST_WR_RESP:  state_q <= ST_WR_PARAM;
        ST_WR_PARAM: state_q <= ST_WR_MSG;
        ST_WR_MSG:   state_q <= ST_POST_POLL;
        ST_POST_POLL: if (poll_rd && (!rd_zero || budget_last)) begin
          res_q   <= rd_class;
          state_q <= ST_RD_ARG;
        end
        ST_RD_ARG: begin
          arg_q   <= reg_rdata_i;
          state_q <= ST_DONE;
        end
        ST_DONE: begin
          if (HALT_ON_ERR && res_q != RES_OK) halt_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_req_o   = 1'b0;
    reg_we_o    = 1'b0;
    reg_addr_o  = RESP_ADDR;
    reg_wdata_o = '0;
    unique case (state_q)
      ST_PRE_POLL, ST_POST_POLL: reg_req_o = tick;
      ST_WR_RESP: begin
        reg_req_o = 1'b1;
        reg_we_o  = 1'b1;
      end
      ST_WR_PARAM: begin
        reg_req_o   = 1'b1;
        reg_we_o    = 1'b1;
        reg_addr_o  = PARAM_ADDR;
        reg_wdata_o = param_q;
      end
      ST_WR_MSG: begin
        reg_req_o   = 1'b1;
        reg_we_o    = 1'b1;
        reg_addr_o  = MSG_ADDR;
        reg_wdata_o = {{PAD_W{1'b0}}, idx_q};
      end
      ST_RD_ARG: begin
        reg_req_o  = 1'b1;
        reg_addr_o = PARAM_ADDR;
      end
      default: ;
    endcase
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign result_o    = res_q;
  assign arg_o       = arg_q;
  assign halt_o      = halt_q;

  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_not_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_msg_after_param_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_o && reg_we_o && reg_addr_o == MSG_ADDR) |->
      $past(reg_req_o && reg_we_o && reg_addr_o == PARAM_ADDR));
  assert_param_after_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_o && reg_we_o && reg_addr_o == PARAM_ADDR) |->
      $past(reg_req_o && reg_we_o && reg_addr_o == RESP_ADDR && reg_wdata_o == '0));
  assert_result_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> result_o != 3'd7);
  assert_halt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
endmodule

// File: tb/test_mbox_cmd_requester.sv
module test_mbox_cmd_requester;
  localparam int CPU = 2;
  localparam int BASE = 2;
  localparam int LIMIT = 20 * BASE;
  localparam logic [7:0] A_MSG = 8'h00, A_PAR = 8'h04, A_RSP = 8'h08;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0;
  logic [15:0] idx = '0;
  logic [31:0] par = '0;
  logic ready, done, halt, rq, we;
  logic [2:0] res;
  logic [31:0] arg, wdata, rdata;
  logic [7:0] addr;

  always #5 clk = ~clk;

  mbox_cmd_requester #(.CLK_PER_US(CPU), .BASE_COUNT(BASE), .HALT_ON_ERR(1'b1)) i_mbox_cmd_requester (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_idx_i(idx), .req_param_i(par), .done_o(done), .result_o(res), .arg_o(arg),
    .halt_o(halt), .reg_req_o(rq), .reg_we_o(we), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  // responder model
  logic [31:0] r_msg = '0, r_par = '0, r_rsp = '0;
  logic do_preset = 1'b0, clr_log = 1'b0;
  logic [31:0] preset_val = '0;
  logic ans_en = 1'b0;
  logic [31:0] ans_code = '0, ans_arg = '0;
  int ans_dly = 0;
  logic pending = 1'b0;
  int dly_cnt = 0, wr_cnt = 0, rd_cnt = 0;
  logic [7:0] wa_log [4];
  logic [31:0] wd_log [4];

  assign rdata = (addr == A_RSP) ? r_rsp : (addr == A_PAR) ? r_par :
                 (addr == A_MSG) ? r_msg : 32'h0;

  always @(posedge clk) begin
    if (clr_log) begin
      wr_cnt <= 0; rd_cnt <= 0; pending <= 1'b0;
    end else begin
      if (rq && we) begin
        if (wr_cnt < 4) begin wa_log[wr_cnt] <= addr; wd_log[wr_cnt] <= wdata; end
        wr_cnt <= wr_cnt + 1;
        if (addr == A_RSP) r_rsp <= wdata;
        if (addr == A_PAR) r_par <= wdata;
        if (addr == A_MSG) begin
          r_msg <= wdata;
          if (ans_en) begin pending <= 1'b1; dly_cnt <= ans_dly; end
        end
      end
      if (rq && !we && addr == A_RSP) rd_cnt <= rd_cnt + 1;
      if (pending) begin
        if (dly_cnt == 0) begin r_rsp <= ans_code; r_par <= ans_arg; pending <= 1'b0; end
        else dly_cnt <= dly_cnt - 1;
      end
    end
    if (do_preset) r_rsp <= preset_val;
  end

  int errors = 0, checks = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_class(input logic [31:0] c);
    case (c)
      32'h0:   return 3'd1;
      32'h1:   return 3'd0;
      32'hFF:  return 3'd2;
      32'hFE:  return 3'd3;
      32'hFD:  return 3'd4;
      32'hFC:  return 3'd5;
      default: return 3'd6;
    endcase
  endfunction

  task automatic run(input logic [15:0] i, input logic [31:0] p, input logic [31:0] pre,
                     input bit en, input logic [31:0] code, input int dly, input logic [31:0] aval,
                     input logic [2:0] e_res, input logic [31:0] e_arg, input bit e_wr,
                     input int e_rd, input string tag);
    bit ready_bad = 0;
    int n = 0;
    @(negedge clk);
    do_preset = 1'b1; preset_val = pre; clr_log = 1'b1;
    ans_en = en; ans_code = code; ans_dly = dly; ans_arg = aval;
    @(negedge clk);
    do_preset = 1'b0; clr_log = 1'b0;
    valid = 1'b1; idx = i; par = p;
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
    while (!done && n < 2000) begin
      if (ready) ready_bad = 1;
      n++;
      @(negedge clk);
    end
    chk(!ready_bad && !ready, {"R1 ready low while busy ", tag}, ready_bad, 0);
    chk(done, {"R1 done seen ", tag}, done, 1);
    chk(res == e_res, {"R7 result ", tag}, res, e_res);
    chk(arg == e_arg, {"R8 argument ", tag}, arg, e_arg);
    if (e_wr) begin
      chk(wr_cnt == 3, {"R5 write count ", tag}, wr_cnt, 3);
      chk(wa_log[0] == A_RSP && wd_log[0] == 0, {"R5 first write clears response ", tag}, wa_log[0], A_RSP);
      chk(wa_log[1] == A_PAR && wd_log[1] == p, {"R5 second write parameter ", tag}, wd_log[1], p);
      chk(wa_log[2] == A_MSG && wd_log[2] == {16'h0, i}, {"R5 third write message ", tag}, wd_log[2], {16'h0, i});
    end else begin
      chk(wr_cnt == 0, {"R2 R3 no write on abort ", tag}, wr_cnt, 0);
    end
    if (e_rd >= 0) chk(rd_cnt == e_rd, {"R2 R6 response read count ", tag}, rd_cnt, e_rd);
    @(negedge clk);
    chk(!done && ready, {"R1 done one cycle then ready ", tag}, done, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1 && done == 0 && halt == 0 && rq == 0, "R1 reset state", {ready, done, halt, rq}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1 && halt == 0, "R1 idle after reset", ready, 1);

    // OK path, halt must stay low
    run(16'h0012, 32'hCAFE0001, 32'h1, 1, 32'h1, 3, 32'h5555AAAA, 3'd0, 32'h5555AAAA, 1, -1, "ok");
    chk(halt == 0, "R9 halt low after OK", halt, 0);
    run(16'hFFFF, 32'h00000000, 32'h1, 1, 32'h1, 0, 32'h1234, 3'd0, 32'h1234, 1, -1, "ok max idx");
    chk(halt == 0, "R9 halt low after OK", halt, 0);

    // R7 sweep of post-send codes and delays
    begin
      logic [31:0] codes [8] = '{32'hFF, 32'hFE, 32'hFD, 32'hFC, 32'hFB, 32'h02, 32'h100, 32'h1};
      for (int k = 0; k < 8; k++) begin
        for (int d = 0; d < 3; d++) begin
          run(16'(k * 7 + d), 32'h1000 + k * 16 + d, 32'h1, 1, codes[k], d * 11, 32'hA000 + k,
              exp_class(codes[k]), 32'hA000 + k, 1, -1, "R7 sweep");
        end
      end
    end
    chk(halt == 1, "R9 halt set after error", halt, 1);

    // R2 pre-send timeout
    run(16'h3, 32'h77, 32'h0, 1, 32'h1, 0, 32'h1, 3'd1, 32'h0, 0, LIMIT, "R2 pre timeout");
    // R3 pre-send undefined codes
    run(16'h4, 32'h78, 32'hFB, 1, 32'h1, 0, 32'h1, 3'd6, 32'h0, 0, 1, "R3 pre 0xFB");
    run(16'h5, 32'h79, 32'h1FF, 1, 32'h1, 0, 32'h1, 3'd6, 32'h0, 0, 1, "R3 pre 0x1FF");
    // R4 defined pre-send codes proceed
    run(16'h6, 32'h7A, 32'hFC, 1, 32'h1, 2, 32'hB1, 3'd0, 32'hB1, 1, -1, "R4 pre busy");
    run(16'h7, 32'h7B, 32'hFF, 1, 32'hFD, 2, 32'hB2, 3'd4, 32'hB2, 1, -1, "R4 pre fail");
    // R6 post-send timeout, argument still read
    run(16'h8, 32'hDEAD0008, 32'h1, 0, 32'h0, 0, 32'h0, 3'd1, 32'hDEAD0008, 1, LIMIT + 1, "R6 post timeout");
    run(16'h9, 32'h99, 32'h1, 1, 32'h1, 1, 32'h42, 3'd0, 32'h42, 1, -1, "R9 ok after error");
    chk(halt == 1, "R9 halt sticky", halt, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule